// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block sits on the receive side of a wireless MAC and decides, for each frame, whether the frame's BSSID belongs to the station, so that the frame may be acknowledged. The frame parser supplies a 48-bit BSSID field and a one-cycle valid strobe. One clock later the block returns a decision strobe and an accept flag.

The comparison covers only the bit positions that a programmable 48-bit mask selects. A frame is accepted when its BSSID and the station MAC address agree in every selected position. Software derives the mask from the set of BSSes it hosts: it keeps the bits that the MAC and all hosted BSSIDs share. One MAC address can then answer for several virtual BSSes. By design, a foreign BSS that happens to agree in the selected bits is also accepted. An all-ones mask gives an exact match, which is the setting for single-BSS and plain station operation.

The MAC address and the mask are held in four 32-bit registers behind a simple write port with byte strobes and a combinational read port. The upper half of the MAC shares its register with a 16-bit auxiliary field that the filter does not use. Byte strobes let software change one half of that register without disturbing the other half.

Top module: `bss_mask_filter`

## Requirements
- R1: When `frm_valid` is high at a clock edge, the decision is accept if and only if `(frm_bssid & mask) == (mac & mask)`, where mac and mask are the programmed 48-bit values.
- R2: `dec_valid` is high for exactly the one cycle that follows each cycle in which `frm_valid` was sampled high. `dec_accept` is never high while `dec_valid` is low.
- R3: Address 0 holds mac[31:0]. A write stores each byte lane whose strobe `reg_be[n]` is set into bits 8n+7..8n, and reading address 0 returns mac[31:0].
- R4: Address 1 holds mac[47:32] in bits 15:0 and an auxiliary field in bits 31:16. A write with strobes 0011 changes only mac[47:32] and leaves the auxiliary field as it was. All 32 bits read back.
- R5: Address 2 holds mask[31:0]. Address 3 holds mask[47:32] in bits 15:0. Bits 31:16 of address 3 ignore writes and always read as zero.
- R6: With the mask all ones, a frame is accepted only when its BSSID equals the MAC address in all 48 bits. A difference in any single bit rejects it.
- R7: Frames that agree with the MAC only in the masked bits are accepted even when they come from a foreign BSS. With mac = 0x1 and mask = 0x2, BSSID 0x6 is rejected, and BSSIDs 0x1, 0x4, 0x9 and 0xD are accepted.
- R8: After reset, all four registers read as zero and every frame is accepted, because the mask is zero.
- R9: A register write in the same cycle as a `frm_valid` strobe does not change the decision for that frame. It first affects the frame sampled in a later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address (0..3) |
| reg_be | input | 4 | Byte strobes for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| frm_valid | input | 1 | BSSID valid strobe, one cycle per frame |
| frm_bssid | input | 48 | BSSID extracted from the incoming frame |
| dec_valid | output | 1 | Decision strobe, one cycle after `frm_valid` |
| dec_accept | output | 1 | Accept flag, qualified by `dec_valid` |

## Verification
The filter is exercised with four kinds of frame pattern. A zero mask after reset must accept everything, which separates an open filter from a missing default. A single-bit mask on a small MAC uses the textbook set of foreign and hosted BSSIDs, which separates a masked compare from a plain equality. An all-ones mask with single-bit flips across the whole 48-bit range catches a lane that is dropped or swapped in the compare. Random masks, MACs and BSSIDs, with writes landing in the same cycle as frames, show whether a write reaches a decision already being made.

// File: rtl/bfilt_pkg.sv
package bfilt_pkg;

  // Register word map of the filter identity
  typedef enum logic [1:0] {
    RA_MAC_LO = 2'd0,
    RA_ID_HI  = 2'd1,
    RA_MSK_LO = 2'd2,
    RA_MSK_HI = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/bfilt_rst_sync.sv
module bfilt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/bfilt_regfile.sv
module bfilt_regfile
  import bfilt_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [DW/8-1:0] be,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mac_o,
  output logic [AW-1:0] mask_o
);

  localparam int NB   = DW / 8;
  localparam int HI_W = AW - DW;
  localparam int HIB  = HI_W / 8;

  logic [DW-1:0]   maclo_q, maclo_d;
  logic [DW-1:0]   idhi_q,  idhi_d;
  logic [DW-1:0]   msklo_q, msklo_d;
  logic [HI_W-1:0] mskhi_q, mskhi_d;
  logic            maclo_en, idhi_en, msklo_en, mskhi_en;
  logic [NB-1:0]   lane_wr;

  // Per-lane write qualifiers
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_wr[b] = we & be[b];
  end

  // Clock enables
  always_comb begin
    maclo_en = (|lane_wr) && (addr == RA_MAC_LO);
    idhi_en  = (|lane_wr) && (addr == RA_ID_HI);
    msklo_en = (|lane_wr) && (addr == RA_MSK_LO);
    mskhi_en = (|lane_wr[HIB-1:0]) && (addr == RA_MSK_HI);
  end

  // Next-state: byte-lane merge with the held value
  always_comb begin
    maclo_d = maclo_q;
    idhi_d  = idhi_q;
    msklo_d = msklo_q;
    mskhi_d = mskhi_q;
    for (int b = 0; b < NB; b++) begin
      if (lane_wr[b]) begin
        maclo_d[8*b +: 8] = wdata[8*b +: 8];
        idhi_d[8*b +: 8]  = wdata[8*b +: 8];
        msklo_d[8*b +: 8] = wdata[8*b +: 8];
      end
    end
    for (int b = 0; b < HIB; b++) begin
      if (lane_wr[b]) mskhi_d[8*b +: 8] = wdata[8*b +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maclo_q <= '0;
      idhi_q  <= '0;
      msklo_q <= '0;
      mskhi_q <= '0;
    end else begin
      if (maclo_en) maclo_q <= maclo_d;
      if (idhi_en)  idhi_q  <= idhi_d;
      if (msklo_en) msklo_q <= msklo_d;
      if (mskhi_en) mskhi_q <= mskhi_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (addr)
      RA_MAC_LO: rdata = maclo_q;
      RA_ID_HI:  rdata = idhi_q;
      RA_MSK_LO: rdata = msklo_q;
      default:   rdata = {{(DW-HI_W){1'b0}}, mskhi_q};
    endcase
  end

  assign mac_o  = {idhi_q[HI_W-1:0], maclo_q};
  assign mask_o = {mskhi_q, msklo_q};

  // R4: a write confined to the low lanes of the upper-ID word keeps the auxiliary field
  p_aux_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == RA_ID_HI && be[NB-1:HIB] == '0) |=> $stable(idhi_q[DW-1:HI_W]));

  // R5: unused upper bits of the upper mask word always read as zero
  p_mskhi_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == RA_MSK_HI) |-> (rdata[DW-1:HI_W] == '0));

endmodule

// File: rtl/bfilt_match.sv
module bfilt_match #(
  parameter int AW = 48
) (
  input  logic [AW-1:0] bssid,
  input  logic [AW-1:0] mac,
  input  logic [AW-1:0] mask,
  output logic          hit
);

  logic [AW-1:0] bit_ok;

  // A position passes when it is not selected or the two addresses agree there
  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = ~mask[i] | ~(bssid[i] ^ mac[i]);
  end

  assign hit = &bit_ok;

endmodule

// File: rtl/bss_mask_filter.sv
module bss_mask_filter #(
  parameter int DW = 32,
  parameter int AW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [3:0]    reg_be,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          frm_valid,
  input  logic [47:0]   frm_bssid,
  output logic          dec_valid,
  output logic          dec_accept
);

  logic          srst_n;
  logic [AW-1:0] mac_w, mask_w;
  logic          hit_w;
  logic          dv_q, dv_d, da_q, da_d;

  bfilt_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  bfilt_regfile #(.DW(DW), .AW(AW)) u_regs (
    .clk    (clk),
    .rst_n  (srst_n),
    .we     (reg_we),
    .addr   (reg_addr),
    .be     (reg_be),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .mac_o  (mac_w),
    .mask_o (mask_w)
  );

  bfilt_match #(.AW(AW)) u_match (
    .bssid (frm_bssid),
    .mac   (mac_w),
    .mask  (mask_w),
    .hit   (hit_w)
  );

  // Next-state of the decision stage; uses identity held before this edge
  always_comb begin
    dv_d = frm_valid;
    da_d = frm_valid & hit_w;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dv_q <= 1'b0;
      da_q <= 1'b0;
    end else begin
      dv_q <= dv_d;
      da_q <= da_d;
    end
  end

  assign dec_valid  = dv_q;
  assign dec_accept = da_q;

  // R2: an accept is always qualified by the decision strobe
  p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!srst_n)
    dec_accept |-> dec_valid);

  // R2: every sampled strobe yields a decision on the next cycle
  p_strobe_answered_r2: assert property (@(posedge clk) disable iff (!srst_n)
    frm_valid |=> dec_valid);

  // R6: a full mask demands equality on every bit
  p_full_mask_exact_r6: assert property (@(posedge clk) disable iff (!srst_n)
    (frm_valid && mask_w == '1) |=> (dec_accept == $past(frm_bssid == mac_w)));

  // R8: an empty mask lets every frame through
  p_empty_mask_open_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (frm_valid && mask_w == '0) |=> dec_accept);

endmodule

// File: tb/bss_mask_filter_bench.sv
module bss_mask_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [3:0]  reg_be = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        frm_valid = 1'b0;
  logic [47:0] frm_bssid = 48'd0;
  logic        dec_valid, dec_accept;

  int n_cmp = 0;
  int n_bad = 0;
  bit checking = 1'b0;
  string dec_tag = "R1";

  always #5 clk = ~clk;

  bss_mask_filter u_bss_mask_filter (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .frm_valid(frm_valid), .frm_bssid(frm_bssid),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // Behavioural reference state
  logic [31:0] m_w0, m_w1, m_w2;
  logic [15:0] m_w3;
  logic        e_v, e_a;

  function automatic logic model_accept(input logic [47:0] b);
    logic [47:0] mac, msk;
    mac = {m_w1[15:0], m_w0};
    msk = {m_w3, m_w2};
    return ((b & msk) == (mac & msk));
  endfunction

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_w0;
      2'd1: return m_w1;
      2'd2: return m_w2;
      default: return {16'h0, m_w3};
    endcase
  endfunction

  function automatic string addr_tag(input logic [1:0] a);
    case (a)
      2'd0: return "R3";
      2'd1: return "R4";
      default: return "R5";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_w0 <= '0; m_w1 <= '0; m_w2 <= '0; m_w3 <= '0;
      e_v <= 1'b0; e_a <= 1'b0;
    end else begin
      e_v <= frm_valid;
      e_a <= frm_valid && model_accept(frm_bssid);
      if (reg_we) begin
        for (int b = 0; b < 4; b++) begin
          if (reg_be[b]) begin
            case (reg_addr)
              2'd0: m_w0[8*b +: 8] <= reg_wdata[8*b +: 8];
              2'd1: m_w1[8*b +: 8] <= reg_wdata[8*b +: 8];
              2'd2: m_w2[8*b +: 8] <= reg_wdata[8*b +: 8];
              default: if (b < 2) m_w3[8*b +: 8] <= reg_wdata[8*b +: 8];
            endcase
          end
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always begin
    @(negedge clk);
    #1;
    if (checking) begin
      n_cmp++;
      if (dec_valid !== e_v || dec_accept !== e_a) begin
        n_bad++;
        $display("FAIL %s decision: got v=%b a=%b expected v=%b a=%b",
                 dec_tag, dec_valid, dec_accept, e_v, e_a);
      end
      n_cmp++;
      if (reg_rdata !== model_read(reg_addr)) begin
        n_bad++;
        $display("FAIL %s read addr %0d: got %h expected %h",
                 addr_tag(reg_addr), reg_addr, reg_rdata, model_read(reg_addr));
      end
    end
  end

  task automatic idle(input logic [1:0] a);
    @(negedge clk);
    reg_we = 1'b0; frm_valid = 1'b0; reg_addr = a;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    frm_valid = 1'b0;
    reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic frame(input logic [47:0] b);
    @(negedge clk);
    reg_we = 1'b0;
    frm_valid = 1'b1; frm_bssid = b;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic set_ident(input logic [47:0] mac, input logic [47:0] msk);
    wr(2'd0, 4'hF, mac[31:0]);
    wr(2'd1, 4'h3, {16'h0, mac[47:32]});
    wr(2'd2, 4'hF, msk[31:0]);
    wr(2'd3, 4'h3, {16'h0, msk[47:32]});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1'b1;

    // R8: reset values and an open filter
    dec_tag = "R8";
    for (int a = 0; a < 4; a++) idle(2'(a));
    for (int i = 0; i < 6; i++) frame({$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);

    // R3, R4, R5: storage, byte strobes, auxiliary field, unused bits
    dec_tag = "R1";
    wr(2'd0, 4'hF, 32'hDEAD_BEEF); idle(2'd0);
    wr(2'd0, 4'h4, 32'h0011_2233); idle(2'd0);
    wr(2'd1, 4'hF, 32'hABCD_1234); idle(2'd1);
    wr(2'd1, 4'h3, 32'h5555_0001); idle(2'd1);
    wr(2'd1, 4'hC, 32'h7E7E_9999); idle(2'd1);
    wr(2'd2, 4'hF, 32'h0F0F_F0F0); idle(2'd2);
    wr(2'd3, 4'hF, 32'hFFFF_A5A5); idle(2'd3);

    // R7: small mask lets a foreign BSS through
    dec_tag = "R7";
    set_ident(48'h1, 48'h2);
    frame(48'h6); frame(48'h1); frame(48'h4); frame(48'h9); frame(48'hD);
    idle(2'd3);

    // R6: full mask, exact match and every single-bit flip
    dec_tag = "R6";
    set_ident(48'h0A1B_2C3D_4E5F, 48'hFFFF_FFFF_FFFF);
    frame(48'h0A1B_2C3D_4E5F);
    for (int i = 0; i < 48; i++) frame(48'h0A1B_2C3D_4E5F ^ (48'h1 << i));

    // R9: write in the same cycle as a frame
    dec_tag = "R9";
    set_ident(48'h0000_0000_00F0, 48'h0000_0000_00FF);
    @(negedge clk);
    frm_valid = 1'b1; frm_bssid = 48'h0000_0000_00F0;
    reg_we = 1'b1; reg_addr = 2'd0; reg_be = 4'h1; reg_wdata = 32'h0000_000F;
    @(negedge clk);
    reg_we = 1'b0; frm_bssid = 48'h0000_0000_00F0;
    @(negedge clk);
    frm_valid = 1'b0;
    idle(2'd0);

    // R1, R2: random identities, frames and back-to-back strobes
    dec_tag = "R2";
    for (int k = 0; k < 40; k++) begin
      logic [47:0] mac, msk;
      mac = {$urandom, $urandom};
      msk = {$urandom, $urandom} | {$urandom, $urandom};
      set_ident(mac, msk);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk);
        frm_valid = ($urandom % 4) != 0;
        frm_bssid = ($urandom % 2) ? (mac ^ ({$urandom, $urandom} & ~msk))
                                   : {$urandom, $urandom};
        reg_we = 1'b0; reg_addr = 2'($urandom);
      end
      idle(2'd1);
    end

    idle(2'd0);
    idle(2'd0);
    finish_run();
  end

endmodule